// File: doc/BRIEF.md
# Input-Pattern Standby Sequencer

This block controls a half-bridge driver's low-power standby mode. Software has no register access here. The only way in or out of standby is a timed sequence on the four ordinary control inputs. The standby pattern is shutdown asserted (low) while the brake input and both channel commands are high. The sequencer samples the inputs on every clock edge, and each time threshold is a parameter counted in clock edges.

The pattern must be held past the standby threshold to enter standby. Leaving standby takes a three-step handshake:

1. Any other input combination must be held past a filter time. This arms the exit.
2. The pattern must then come back and be held for a window that is longer than the wake-up minimum and no longer than the standby threshold.
3. The pattern must then be released.

After that, a wake-up delay runs. During the delay both outputs are low. Then the output enable returns, and the downstream command decode follows the inputs again. While the standby flag is high, the output enable is low, so the gate outputs are held in their safe low state.

Top module: `stby_seq`

## Requirements
- R1: The standby pattern is exactly shut_n=0, brk_n=1, cmd_a=1, cmd_b=1, read as the vector {shut_n,brk_n,cmd_a,cmd_b}=4'b0111. Every other combination counts as non-pattern, including all inputs high.
- R2: During and after reset the sequencer is active: out_en=1 and stby=0.
- R3: From the active state, the pattern sampled on T_ENTER+1 consecutive edges sets stby=1 and out_en=0 right after the last of those edges. A run of T_ENTER edges or fewer leaves the outputs unchanged.
- R4: In standby, input changes do not move the outputs, and non-pattern runs of T_FILT edges or fewer do not start an exit.
- R5: In standby, non-pattern sampled on T_FILT+1 consecutive edges arms the exit. Only non-pattern edges sampled while in standby are counted. Arming does not change the outputs.
- R6: After arming, a pattern run of L edges with T_WAKE < L <= T_ENTER, followed by a non-pattern edge, clears stby right after that edge. out_en stays 0.
- R7: A pattern run with L <= T_WAKE that ends in non-pattern leaves stby=1 and disarms the exit. The filter count restarts at the next edge.
- R8: A pattern run that reaches T_ENTER+1 edges during an exit attempt abandons the attempt. stby stays 1, and a fresh filter period is needed.
- R9: After exit, stby=0 and out_en=0 hold for exactly T_AWAKE cycles whatever the inputs do. After that out_en=1, and pattern counting for a new entry starts at the first active edge.
- R10: stby and out_en are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock; every threshold is counted in its edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| shut_n | input | 1 | Shutdown control input, active low |
| brk_n | input | 1 | Brake control input, active low |
| cmd_a | input | 1 | Channel A command, active high |
| cmd_b | input | 1 | Channel B command, active high |
| stby | output | 1 | High while the driver is in standby |
| out_en | output | 1 | Enables the downstream command decode |

## Verification
The hardest state to reach from the ports is an exit window that ends exactly at its boundaries. These are a pattern run of T_WAKE versus T_WAKE+1 edges, and of T_ENTER versus T_ENTER+1 edges, each reached only after a correctly filtered arming run. Directed sequences walk each boundary on both sides, starting from a known standby entry. Seeded random segments follow, with run lengths drawn around the filter and standby thresholds, so that short glitches, abandoned attempts and full wake-ups occur in many orders.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    S_ACTIVE,
    S_ENTERING,
    S_STANDBY,
    S_EXIT_ARMED,
    S_EXIT_WINDOW,
    S_WAKING
  } seq_state_t;

  // Standby pattern: shutdown asserted, brake released, both commands high.
  function automatic logic is_stby_pat(input logic shut_n, input logic brk_n,
                                       input logic cmd_a, input logic cmd_b);
    return !shut_n && brk_n && cmd_a && cmd_b;
  endfunction

  // True once a run of 'seen' sampled edges is strictly longer than 'lim'.
  function automatic logic run_over(input int unsigned seen, input int unsigned lim);
    return seen > lim;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/stby_pat_det.sv
module stby_pat_det
  import stby_pkg::*;
(
  input  logic shut_n,
  input  logic brk_n,
  input  logic cmd_a,
  input  logic cmd_b,
  output logic pat
);
  assign pat = is_stby_pat(shut_n, brk_n, cmd_a, cmd_b);
endmodule

// File: rtl/stby_cnt.sv
module stby_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int unsigned T_ENTER = 40,
  parameter int unsigned T_FILT  = 3,
  parameter int unsigned T_WAKE  = 8,
  parameter int unsigned T_AWAKE = 16,
  parameter int unsigned CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pat,
  input  logic [CW-1:0] cnt,
  output seq_state_t    state,
  output logic          clr,
  output logic          enter_evt,
  output logic          exit_evt,
  output logic          abandon_evt
);
  seq_state_t nxt;
  int unsigned cnt_u;

  assign cnt_u = 32'(cnt);

  always_comb begin
    nxt         = state;
    enter_evt   = 1'b0;
    exit_evt    = 1'b0;
    abandon_evt = 1'b0;
    unique case (state)
      S_ACTIVE:
        if (pat) nxt = S_ENTERING;
      S_ENTERING:
        if (!pat) nxt = S_ACTIVE;
        else if (run_over(cnt_u + 2, T_ENTER)) begin
          nxt       = S_STANDBY;
          enter_evt = 1'b1;
        end
      S_STANDBY:
        if (!pat && run_over(cnt_u + 1, T_FILT)) nxt = S_EXIT_ARMED;
      S_EXIT_ARMED:
        if (pat) nxt = S_EXIT_WINDOW;
      S_EXIT_WINDOW:
        if (pat) begin
          if (run_over(cnt_u + 2, T_ENTER)) begin
            nxt         = S_STANDBY;
            abandon_evt = 1'b1;
          end
        end else if (run_over(cnt_u + 1, T_WAKE)) begin
          nxt      = S_WAKING;
          exit_evt = 1'b1;
        end else begin
          nxt = S_STANDBY;
        end
      S_WAKING:
        if (run_over(cnt_u + 2, T_AWAKE)) nxt = S_ACTIVE;
      default:
        nxt = S_ACTIVE;
    endcase
  end

  // Counter restarts on every state change; in standby it also restarts on
  // a pattern edge so it tracks the current non-pattern run only.
  assign clr = (nxt != state) || (state == S_STANDBY && pat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_ACTIVE;
    else        state <= nxt;
  end
endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
#(
  parameter int unsigned T_ENTER = 40,
  parameter int unsigned T_FILT  = 3,
  parameter int unsigned T_WAKE  = 8,
  parameter int unsigned T_AWAKE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_n,
  input  logic brk_n,
  input  logic cmd_a,
  input  logic cmd_b,
  output logic stby,
  output logic out_en
);
  localparam int unsigned MAXT = max4(T_ENTER, T_FILT, T_WAKE, T_AWAKE);
  localparam int unsigned CW   = $clog2(MAXT + 2);

  logic          pat_w;
  logic          clr_w;
  logic [CW-1:0] cnt_w;
  seq_state_t    state_w;
  logic          enter_evt;
  logic          exit_evt;
  logic          abandon_evt;

  stby_pat_det u_pat (
    .shut_n(shut_n), .brk_n(brk_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .pat(pat_w)
  );

  stby_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .cnt(cnt_w)
  );

  stby_fsm #(
    .T_ENTER(T_ENTER), .T_FILT(T_FILT), .T_WAKE(T_WAKE),
    .T_AWAKE(T_AWAKE), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pat(pat_w), .cnt(cnt_w), .state(state_w),
    .clr(clr_w), .enter_evt(enter_evt), .exit_evt(exit_evt),
    .abandon_evt(abandon_evt)
  );

  assign stby   = (state_w == S_STANDBY) || (state_w == S_EXIT_ARMED) ||
                  (state_w == S_EXIT_WINDOW);
  assign out_en = (state_w == S_ACTIVE) || (state_w == S_ENTERING);
endmodule

// File: rtl/stby_seq_chk.sv
module stby_seq_chk #(
  parameter int unsigned T_ENTER = 40,
  parameter int unsigned T_AWAKE = 16
) (
  input logic clk,
  input logic rst_n,
  input logic pat,
  input logic stby,
  input logic out_en,
  input logic enter_evt,
  input logic exit_evt,
  input logic abandon_evt
);
  logic [31:0] prun;
  logic [31:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prun <= '0;
      wcnt <= '0;
    end else begin
      prun <= (pat && out_en) ? prun + 1 : '0;
      wcnt <= (!stby && !out_en) ? wcnt + 1 : '0;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stby && out_en));

  a_r3_enter_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby) |-> prun == T_ENTER + 1);

  a_r3_enter_evt: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> stby && !out_en);

  a_r6_exit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby) |-> !out_en && $past(!pat));

  a_r6_exit_evt: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> !stby && !out_en);

  a_r8_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_evt |=> stby);

  a_r9_wake_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> wcnt == T_AWAKE);
endmodule

bind stby_seq stby_seq_chk #(.T_ENTER(T_ENTER), .T_AWAKE(T_AWAKE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pat(pat_w), .stby(stby), .out_en(out_en),
  .enter_evt(enter_evt), .exit_evt(exit_evt), .abandon_evt(abandon_evt)
);

// File: tb/test_stby_seq.sv
module test_stby_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_ENTER = 40;
  localparam int T_FILT  = 3;
  localparam int T_WAKE  = 8;
  localparam int T_AWAKE = 16;
  localparam logic [3:0] PAT = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shut_n = 1'b1, brk_n = 1'b0, cmd_a = 1'b0, cmd_b = 1'b0;
  logic stby, out_en;

  int total = 0, bad = 0;
  int mode = 0, pr = 0, nr = 0, wl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_seq #(.T_ENTER(T_ENTER), .T_FILT(T_FILT), .T_WAKE(T_WAKE),
             .T_AWAKE(T_AWAKE)) i_stby_seq (
    .clk(clk), .rst_n(rst_n), .shut_n(shut_n), .brk_n(brk_n),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .stby(stby), .out_en(out_en)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference: modes 0 run, 1 sleep, 2 armed, 3 window, 4 waking.
  task automatic ref_step(input logic [3:0] v);
    bit p;
    int prev;
    p = (v == PAT);
    prev = pr;
    pr = p ? pr + 1 : 0;
    nr = p ? 0 : nr + 1;
    case (mode)
      0: if (p && pr > T_ENTER) mode = 1;
      1: if (!p && nr > T_FILT) mode = 2;
      2: if (p) mode = 3;
      3: if (p && pr > T_ENTER) begin mode = 1; nr = 0; end
         else if (!p) begin
           if (prev > T_WAKE) begin mode = 4; wl = T_AWAKE; end
           else begin mode = 1; nr = 0; end
         end
      default: begin wl--; if (wl == 0) begin mode = 0; pr = 0; end end
    endcase
  endtask

  task automatic step(input logic [3:0] v);
    string tag;
    {shut_n, brk_n, cmd_a, cmd_b} = v;
    @(posedge clk);
    ref_step(v);
    @(negedge clk);
    tag = (mode == 0) ? "R3" : (mode == 4) ? "R9" : "R4";
    chk(tag, "stby", int'(stby), int'(mode >= 1 && mode <= 3));
    chk(tag, "out_en", int'(out_en), int'(mode == 0));
    chk("R10", "stby&out_en", int'(stby && out_en), 0);
  endtask

  function automatic logic [3:0] non_pat();
    logic [3:0] v;
    do v = 4'($urandom_range(0, 15)); while (v == PAT);
    return v;
  endfunction

  task automatic hold(input logic [3:0] v, input int n);
    for (int i = 0; i < n; i++) step(v);
  endtask

  task automatic hold_np(input int n);
    for (int i = 0; i < n; i++) step(non_pat());
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("R2", "out_en in reset", int'(out_en), 1);
    chk("R2", "stby in reset", int'(stby), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "out_en after reset", int'(out_en), 1);
    chk("R2", "stby after reset", int'(stby), 0);

    // R1: near-miss patterns never enter standby
    hold(4'b1111, T_ENTER + 5);
    hold(4'b0110, T_ENTER + 5);
    hold(4'b0011, T_ENTER + 5);
    chk("R1", "near-miss pattern out_en", int'(out_en), 1);

    // R3: run of exactly T_ENTER edges does nothing, T_ENTER+1 enters
    hold(PAT, T_ENTER);
    step(4'b1000);
    chk("R3", "short run out_en", int'(out_en), 1);
    hold(PAT, T_ENTER + 1);
    chk("R3", "entry stby", int'(stby), 1);
    chk("R3", "entry out_en", int'(out_en), 0);

    // R4: short non-pattern bursts while in standby
    for (int k = 0; k < 10; k++) begin
      hold_np($urandom_range(1, T_FILT));
      hold(PAT, $urandom_range(1, 5));
    end
    chk("R4", "stby after short bursts", int'(stby), 1);

    // R5 then R7: arm, then a too-short window
    hold_np(T_FILT + 1);
    chk("R5", "armed stby", int'(stby), 1);
    hold(PAT, T_WAKE);
    step(4'b1000);
    chk("R7", "short window stby", int'(stby), 1);
    hold(PAT, T_WAKE + 1);
    step(4'b1000);
    chk("R7", "disarmed after short window", int'(stby), 1);

    // R8: abandon by over-long window
    hold(PAT, 2);
    hold_np(T_FILT + 1);
    hold(PAT, T_ENTER + 1);
    chk("R8", "abandon stby", int'(stby), 1);
    step(4'b1000);
    hold(PAT, T_WAKE + 1);
    step(4'b1000);
    chk("R8", "disarmed after abandon", int'(stby), 1);

    // R6 lower boundary and R9 wake delay with pattern ignored
    hold_np(T_FILT + 1);
    hold(PAT, T_WAKE + 1);
    step(4'b1000);
    chk("R6", "exit stby", int'(stby), 0);
    chk("R6", "exit out_en", int'(out_en), 0);
    hold(PAT, T_AWAKE - 1);
    chk("R9", "waking out_en", int'(out_en), 0);
    step(PAT);
    chk("R9", "awake out_en", int'(out_en), 1);
    hold(4'b1000, 2);

    // R6 upper boundary: window of exactly T_ENTER edges
    hold(PAT, T_ENTER + 1);
    hold_np(T_FILT + 1);
    hold(PAT, T_ENTER);
    step(4'b1000);
    chk("R6", "upper window exit stby", int'(stby), 0);
    hold_np(T_AWAKE);
    chk("R9", "awake after upper exit", int'(out_en), 1);

    // Seeded random segments
    for (int s = 0; s < 400; s++) begin
      if ($urandom_range(0, 99) < 55) hold(PAT, $urandom_range(1, T_ENTER + 4));
      else hold_np($urandom_range(1, T_FILT + 3));
    end

    summary();
    $finish;
  end
endmodule